// File: doc/BRIEF.md
# Handshaked Register Bank Access Port

This block gives a cyclic process-data exchange access to a bank of up to 128 registers of 32 bits each. Each cycle the host drives an output image and receives an input image. The output image holds a write request with its address and data, and a separate read address. The input image holds the following fields:

- a write acknowledge and a write-success flag;
- the address actually read, with a read-abort flag and the read data;
- an auxiliary read channel that always shows one register, chosen by a build-time parameter;
- two sticky status bits that latch overflow and zero-crossing events reported by an external counter.

A write is a level handshake. The host raises the request. The block performs the write or rejects it and raises the acknowledge one clock later, and the success flag then tells which of the two happened. The host drops the request, and the acknowledge falls on the next clock. Two parameter masks set which addresses exist and which addresses may be written. A read of an address that does not exist returns the abort bit and forced-zero data. Registers are cleared by reset. In this block a register that may not be written keeps its reset value, so it always reads as zero.

Top module: `regbank_port`

## Requirements
- R1: Read and write addresses are 7 bits wide (0 to 127) and register data is 32 bits wide. Every address in that range can be requested on both paths.
- R2: When `wr_req` is 1 and `wr_ack` is 0 at a clock edge, the write is taken and `wr_ack` is 1 after that edge. While `wr_ack` is 1, a request that stays high performs no further write, even if `wr_addr` or `wr_data` change.
- R3: When `wr_req` is 0 at a clock edge, both `wr_ack` and `wr_ok` are 0 after that edge.
- R4: When `wr_ack` rises, `wr_ok` is 1 if the address sampled with the request is both implemented and writable, and 0 otherwise. `wr_ok` is never 1 while `wr_ack` is 0.
- R5: A rejected write leaves every register unchanged. With the default masks, addresses 16 to 23 are read-only and addresses 96 to 127 are unimplemented.
- R6: A read address is answered two clocks after it is sampled. `rd_addr_echo` then shows that address. For an unimplemented address, `rd_abort` is 1 and `rd_data` is 0. For an implemented address, `rd_abort` is 0 and `rd_data` is the register contents.
- R7: `aux_data` shows the contents of register `AUX_ADDR` (default 5), with the same two-clock delay after a write.
- R8: `sts_ovf` becomes 1 on the clock after `cnt_ovf_evt` is 1, and holds until cleared.
- R9: `sts_zc` becomes 1 on the clock after `cnt_zc_evt` is 1, and holds until cleared.
- R10: A `sts_clear` pulse clears both status bits on the next clock. An event in the same cycle as the clear wins, so that bit stays 1.
- R11: Synchronous reset clears every register, so each one reads 0 afterwards. It also clears both status bits, `wr_ack`, `wr_ok`, `rd_abort`, `rd_data`, `rd_addr_echo` and `aux_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request level |
| wr_addr | input | 7 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 7 | Read register address |
| cnt_ovf_evt | input | 1 | Counter overflow event pulse |
| cnt_zc_evt | input | 1 | Counter zero-crossing event pulse |
| sts_clear | input | 1 | Clears both sticky status bits |
| wr_ack | output | 1 | Write acknowledge |
| wr_ok | output | 1 | Write succeeded (valid while wr_ack is 1) |
| rd_addr_echo | output | 7 | Address of the register being returned |
| rd_abort | output | 1 | Read rejected, rd_data forced to zero |
| rd_data | output | 32 | Read data |
| aux_data | output | 32 | Contents of the fixed auxiliary register |
| sts_ovf | output | 1 | Sticky overflow status |
| sts_zc | output | 1 | Sticky zero-crossing status |

## Verification
The handshake properties assume that the host behaves as a level-driven requester: it holds `wr_req` steady around clock edges and treats the address sampled with a rising request as the one being written. The bench drives every input on the falling edge and samples on the next falling edge. It keeps the request high until it has seen the acknowledge, and it never reads an address in the same cycle that the address is written, so the ordering of a read and a write in one cycle never arises. The status properties place no limits on the event inputs, and the bench pulses them alone and together with the clear.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned REG_ADDR_W = 7;
  localparam int unsigned REG_DATA_W = 32;
  localparam int unsigned STS_BITS   = 2;
  localparam int unsigned STS_OVF    = 0;
  localparam int unsigned STS_ZC     = 1;
endpackage

// File: rtl/regbank_wr_ctrl.sv
module regbank_wr_ctrl #(
  parameter int unsigned ADDR_W = 7,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = '1,
  parameter logic [(1<<ADDR_W)-1:0] WR_MASK   = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              we,
  output logic              ack,
  output logic              ok
);
  localparam logic [(1<<ADDR_W)-1:0] ALLOWED = IMPL_MASK & WR_MASK;

  logic start;
  logic permitted;

  always_comb begin
    start     = req && !ack;
    permitted = ALLOWED[addr];
    we        = start && permitted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0;
      ok  <= 1'b0;
    end else if (!req) begin
      ack <= 1'b0;
      ok  <= 1'b0;
    end else if (start) begin
      ack <= 1'b1;
      ok  <= permitted;
    end
  end
endmodule

// File: rtl/regbank_ram.sv
module regbank_ram #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NRD    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           waddr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NRD-1:0][ADDR_W-1:0]  raddr,
  output logic [NRD-1:0][DATA_W-1:0]  rdata,
  output logic [NRD-1:0]              rvld
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  // Array without reset so it maps onto block RAM; the written flags
  // carry the reset state of the bank.
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     written        <= '0;
    else if (we) written[waddr] <= 1'b1;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[p] <= mem[raddr[p]];
    end
    always_ff @(posedge clk) begin
      if (rst) rvld[p] <= 1'b0;
      else     rvld[p] <= written[raddr[p]];
    end
  end
endmodule

// File: rtl/regbank_rd_gate.sv
module regbank_rd_gate #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] ram_q,
  input  logic              ram_vld,
  output logic [ADDR_W-1:0] addr_out,
  output logic              abort,
  output logic [DATA_W-1:0] data
);
  logic [ADDR_W-1:0] addr_s1;
  logic              impl_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_s1 <= '0;
      impl_s1 <= 1'b1;
    end else begin
      addr_s1 <= addr_in;
      impl_s1 <= IMPL_MASK[addr_in];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      abort    <= 1'b0;
      data     <= '0;
    end else begin
      addr_out <= addr_s1;
      abort    <= !impl_s1;
      data     <= (impl_s1 && ram_vld) ? ram_q : '0;
    end
  end
endmodule

// File: rtl/regbank_sticky.sv
module regbank_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         flag[i] <= 1'b0;
      else if (evt[i]) flag[i] <= 1'b1;
      else if (clr)    flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/regbank_port.sv
module regbank_port
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = REG_ADDR_W,
  parameter int unsigned DATA_W = REG_DATA_W,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = 128'h0000_0000_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
  parameter logic [(1<<ADDR_W)-1:0] WR_MASK   = 128'h0000_0000_FFFF_FFFF_FFFF_FFFF_FF00_FFFF,
  parameter int unsigned AUX_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              cnt_ovf_evt,
  input  logic              cnt_zc_evt,
  input  logic              sts_clear,
  output logic              wr_ack,
  output logic              wr_ok,
  output logic [ADDR_W-1:0] rd_addr_echo,
  output logic              rd_abort,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] aux_data,
  output logic              sts_ovf,
  output logic              sts_zc
);
  localparam int unsigned NRD    = 2;
  localparam int unsigned P_MAIN = 0;
  localparam int unsigned P_AUX  = 1;
  localparam logic [ADDR_W-1:0] AUX_A = ADDR_W'(AUX_ADDR);

  logic                       we;
  logic [NRD-1:0][ADDR_W-1:0] raddr;
  logic [NRD-1:0][DATA_W-1:0] rq;
  logic [NRD-1:0]             rv;
  logic [STS_BITS-1:0]        evt;
  logic [STS_BITS-1:0]        flag;

  regbank_wr_ctrl #(
    .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK), .WR_MASK(WR_MASK)
  ) u_wr (
    .clk(clk), .rst(rst), .req(wr_req), .addr(wr_addr),
    .we(we), .ack(wr_ack), .ok(wr_ok)
  );

  always_comb begin
    raddr[P_MAIN] = rd_addr;
    raddr[P_AUX]  = AUX_A;
  end

  regbank_ram #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NRD)
  ) u_ram (
    .clk(clk), .rst(rst), .we(we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(raddr), .rdata(rq), .rvld(rv)
  );

  regbank_rd_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)
  ) u_rd (
    .clk(clk), .rst(rst), .addr_in(rd_addr), .ram_q(rq[P_MAIN]),
    .ram_vld(rv[P_MAIN]), .addr_out(rd_addr_echo), .abort(rd_abort),
    .data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) aux_data <= '0;
    else     aux_data <= (IMPL_MASK[AUX_A] && rv[P_AUX]) ? rq[P_AUX] : '0;
  end

  always_comb begin
    evt[STS_OVF] = cnt_ovf_evt;
    evt[STS_ZC]  = cnt_zc_evt;
    sts_ovf      = flag[STS_OVF];
    sts_zc       = flag[STS_ZC];
  end

  regbank_sticky #(.N(STS_BITS)) u_sts (
    .clk(clk), .rst(rst), .evt(evt), .clr(sts_clear), .flag(flag)
  );
endmodule

// File: rtl/regbank_port_chk.sv
module regbank_port_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = '1,
  parameter logic [(1<<ADDR_W)-1:0] WR_MASK   = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cnt_ovf_evt,
  input logic              cnt_zc_evt,
  input logic              sts_clear,
  input logic              wr_ack,
  input logic              wr_ok,
  input logic [ADDR_W-1:0] rd_addr_echo,
  input logic              rd_abort,
  input logic [DATA_W-1:0] rd_data,
  input logic              sts_ovf,
  input logic              sts_zc
);
  localparam logic [(1<<ADDR_W)-1:0] ALLOWED = IMPL_MASK & WR_MASK;

  p_ack_rise_r2: assert property (@(posedge clk) disable iff (rst)
    wr_req && !wr_ack |=> wr_ack);
  p_ack_drop_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> !wr_ack && !wr_ok);
  p_ok_needs_ack_r4: assert property (@(posedge clk) disable iff (rst)
    wr_ok |-> wr_ack);
  p_ok_matches_mask_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_ack) |-> wr_ok == ALLOWED[$past(wr_addr)]);
  p_abort_zero_data_r6: assert property (@(posedge clk) disable iff (rst)
    rd_abort |-> rd_data == '0);
  p_abort_vs_echo_r6: assert property (@(posedge clk) disable iff (rst)
    rd_abort == !IMPL_MASK[rd_addr_echo]);
  p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_ovf_evt |=> sts_ovf);
  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (rst)
    sts_ovf && !sts_clear |=> sts_ovf);
  p_zc_set_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_zc_evt |=> sts_zc);
  p_zc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    sts_zc && !sts_clear |=> sts_zc);
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    sts_clear && !cnt_ovf_evt && !cnt_zc_evt |=> !sts_ovf && !sts_zc);
  p_reset_r11: assert property (@(posedge clk)
    rst |=> !wr_ack && !wr_ok && !rd_abort && rd_data == '0 && !sts_ovf && !sts_zc);
endmodule

bind regbank_port regbank_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK), .WR_MASK(WR_MASK)
) u_chk (
  .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr),
  .cnt_ovf_evt(cnt_ovf_evt), .cnt_zc_evt(cnt_zc_evt), .sts_clear(sts_clear),
  .wr_ack(wr_ack), .wr_ok(wr_ok), .rd_addr_echo(rd_addr_echo),
  .rd_abort(rd_abort), .rd_data(rd_data), .sts_ovf(sts_ovf), .sts_zc(sts_zc)
);

// File: tb/regbank_port_tb.sv
module regbank_port_tb;
  localparam int AUX = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_req = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic        cnt_ovf_evt = 1'b0;
  logic        cnt_zc_evt = 1'b0;
  logic        sts_clear = 1'b0;
  logic        wr_ack, wr_ok, rd_abort, sts_ovf, sts_zc;
  logic [6:0]  rd_addr_echo;
  logic [31:0] rd_data, aux_data;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  regbank_port u_dut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt_ovf_evt(cnt_ovf_evt), .cnt_zc_evt(cnt_zc_evt),
    .sts_clear(sts_clear), .wr_ack(wr_ack), .wr_ok(wr_ok),
    .rd_addr_echo(rd_addr_echo), .rd_abort(rd_abort), .rd_data(rd_data),
    .aux_data(aux_data), .sts_ovf(sts_ovf), .sts_zc(sts_zc)
  );

  function automatic bit impl_a(int a);
    return a < 96;
  endfunction
  function automatic bit wrable(int a);
    return impl_a(a) && !(a >= 16 && a < 24);
  endfunction
  function automatic logic [31:0] pat(int a, int k);
    return (32'(k) * 32'h1357_9BDF) ^ (32'(a) * 32'h0102_0408) ^ 32'h5A00_00A5;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
      finish_run();
    end
  end

  // Drive on negedge; a write completes one edge later.
  task automatic do_write(int a, logic [31:0] d, string req);
    wr_addr = 7'(a);
    wr_data = d;
    wr_req  = 1'b1;
    @(negedge clk);
    check({req, " R2 ack"}, 32'(wr_ack), 32'd1);
    check({req, " R4 ok"}, 32'(wr_ok), 32'(wrable(a)));
    wr_req = 1'b0;
    @(negedge clk);
    check("R3 ack low", 32'(wr_ack), 32'd0);
    check("R3 ok low", 32'(wr_ok), 32'd0);
  endtask

  task automatic do_read(int a, logic [31:0] exp_d, string req);
    rd_addr = 7'(a);
    @(negedge clk);
    @(negedge clk);
    check({req, " R6 echo"}, 32'(rd_addr_echo), 32'(a));
    check({req, " R6 abort"}, 32'(rd_abort), 32'(!impl_a(a)));
    check({req, " R6 data"}, rd_data, exp_d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 ack", 32'(wr_ack), 0);
    check("R11 ok", 32'(wr_ok), 0);
    check("R11 rd_data", rd_data, 0);
    check("R11 abort", 32'(rd_abort), 0);
    check("R11 aux", aux_data, 0);
    check("R11 sts", {30'd0, sts_zc, sts_ovf}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R4 R5: write sweep over all addresses
    for (int a = 0; a < 128; a++) do_write(a, pat(a, 1), "R1 sweep");
    for (int a = 0; a < 128; a++)
      do_read(a, wrable(a) ? pat(a, 1) : 32'd0, "R1 R5 readback");
    check("R7 aux", aux_data, pat(AUX, 1));

    // Second pattern on the writable set, R5 keeps read-only at zero
    for (int a = 0; a < 128; a += 3) do_write(a, pat(a, 2), "R4 second");
    for (int a = 0; a < 128; a++)
      do_read(a, wrable(a) ? pat(a, (a % 3 == 0) ? 2 : 1) : 32'd0, "R5 overwrite");

    // R7: aux follows a new write after two clocks
    wr_addr = 7'(AUX); wr_data = 32'hC0DE_0005; wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    check("R7 aux not yet", aux_data, pat(AUX, 1));
    @(negedge clk);
    @(negedge clk);
    check("R7 aux updated", aux_data, 32'hC0DE_0005);

    // R2: request held high while acked writes nothing more
    wr_addr = 7'd40; wr_data = 32'h1111_2222; wr_req = 1'b1;
    @(negedge clk);
    check("R2 held ack", 32'(wr_ack), 1);
    wr_data = 32'h3333_4444; wr_addr = 7'd41;
    repeat (3) @(negedge clk);
    check("R2 still acked", 32'(wr_ack), 1);
    wr_req = 1'b0;
    @(negedge clk);
    do_read(40, 32'h1111_2222, "R2 held first");
    do_read(41, pat(41, 1), "R2 held other");

    // R8 R9 R10: sticky status
    cnt_ovf_evt = 1'b1;
    @(negedge clk);
    cnt_ovf_evt = 1'b0;
    check("R8 ovf set", 32'(sts_ovf), 1);
    check("R9 zc idle", 32'(sts_zc), 0);
    repeat (4) @(negedge clk);
    check("R8 ovf held", 32'(sts_ovf), 1);
    cnt_zc_evt = 1'b1;
    @(negedge clk);
    cnt_zc_evt = 1'b0;
    check("R9 zc set", 32'(sts_zc), 1);
    sts_clear = 1'b1;
    @(negedge clk);
    sts_clear = 1'b0;
    check("R10 clear", {30'd0, sts_zc, sts_ovf}, 0);
    sts_clear = 1'b1; cnt_zc_evt = 1'b1;
    @(negedge clk);
    sts_clear = 1'b0; cnt_zc_evt = 1'b0;
    check("R10 evt wins zc", 32'(sts_zc), 1);
    check("R10 ovf cleared", 32'(sts_ovf), 0);
    cnt_ovf_evt = 1'b1;
    @(negedge clk);
    cnt_ovf_evt = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R11: reset mid-run
    check("R11 sts after", {30'd0, sts_zc, sts_ovf}, 0);
    rst = 1'b0;
    @(negedge clk);
    do_read(AUX, 32'd0, "R11 cleared reg");
    do_read(0, 32'd0, "R11 cleared reg0");
    check("R11 aux cleared", aux_data, 0);
    do_read(100, 32'd0, "R6 unimpl");
    finish_run();
  end
endmodule